// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Qualifier

This block compares two divided clocks, a divided oscillator signal and a divided reference signal, by their rising edges. Whichever edge arrives first opens an active-low correction pulse. The pulse closes once the other edge has arrived. `up_n_o` goes low when the reference edge leads, which asks for a higher oscillator frequency. `dn_n_o` goes low when the oscillator edge leads, which asks for a lower one. The pulse length in sample-clock cycles grows with the phase gap between the edges.

Both inputs are sampled by a fast system clock and are treated as synchronous to it. A raw activity indicator is high while either correction output is low. A lock qualifier measures the length of every comparison. It raises a clean lock flag after a run of tight comparisons and drops the flag at the first loose one.

Top module: `pfd_lock_det`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `up_n_o` and `dn_n_o` are 1, and `lock_raw_o` and `locked_o` are 0.
- R2: When the reference input rises d ≥ 1 samples before the oscillator input, `up_n_o` is low for d+1 consecutive cycles starting on the cycle the reference rise is sampled. `dn_n_o` is low only in the last of those cycles.
- R3: When the oscillator input rises d ≥ 1 samples before the reference input, `dn_n_o` is low for d+1 consecutive cycles. `up_n_o` is low only in the last of those cycles.
- R4: A cycle in which both outputs are low is always followed by a cycle in which both are high. This ends the comparison.
- R5: Rising edges sampled on the same cycle drive both outputs low for exactly one cycle, which gives a comparison length of 1.
- R6: `lock_raw_o` is the NAND of `up_n_o` and `dn_n_o`. It is 1 in every cycle where either output is low.
- R7: The length of a comparison is the number of cycles in which `lock_raw_o` is 1. `locked_o` rises in the cycle after the 16th consecutive comparison whose length is at most 2, and not earlier.
- R8: A comparison longer than 2 cycles clears `locked_o` in the cycle after it ends and restarts the run count from zero.
- R9: Falling input edges, and levels held high, start no pulse. Both outputs stay high after inputs fall while no comparison is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, much faster than either input |
| rst | input | 1 | Synchronous active-high reset |
| fp_div_i | input | 1 | Divided oscillator signal |
| fc_div_i | input | 1 | Divided reference signal |
| up_n_o | output | 1 | Active-low raise-frequency pulse |
| dn_n_o | output | 1 | Active-low lower-frequency pulse |
| lock_raw_o | output | 1 | NAND of the two correction outputs |
| locked_o | output | 1 | Qualified lock flag |

## Verification
The hardest condition to reach from the ports is the edge of the lock run. The 15th and 16th tight comparisons must be told apart, and so must a length-2 comparison and a length-3 comparison. The driver therefore places every second edge at an exact sample offset from the first. It predicts each comparison's length and the lock flag that should follow, using a run-count model of its own. Long runs of lengths 1 and 2 lead up to the threshold. A single length-3 or length-4 comparison then tests that the flag drops and the run count restarts.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    // Pulse flop pair: up = reference led, dn = oscillator led
    typedef struct packed {
        logic up;
        logic dn;
    } pump_t;

    localparam int DEF_LOCK_RUN  = 16;
    localparam int DEF_WIDTH_LIM = 2;
    localparam int DEF_WCNT_W    = 8;

    // Input channel indices for the edge detector
    localparam int CH_VCO = 0;
    localparam int CH_REF = 1;

    function automatic logic is_active(pump_t s);
        return s.up | s.dn;
    endfunction

    function automatic logic is_closing(pump_t s);
        return s.up & s.dn;
    endfunction
endpackage

// File: rtl/pfd_edge.sv
module pfd_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_ch
            logic prev_q;
            always_ff @(posedge clk) begin
                prev_q <= lvl[i];
            end
            assign rise[i] = lvl[i] & ~prev_q;
        end
    endgenerate
endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rise_ref,
    input  logic  rise_vco,
    output pump_t st
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (is_closing(st)) begin
            st <= '0;
        end else begin
            st.up <= st.up | rise_ref;
            st.dn <= st.dn | rise_vco;
        end
    end
endmodule

// File: rtl/pfd_lockq.sv
module pfd_lockq
    import pfd_pkg::*;
#(
    parameter int LOCK_RUN  = DEF_LOCK_RUN,
    parameter int WIDTH_LIM = DEF_WIDTH_LIM,
    parameter int WCNT_W    = DEF_WCNT_W
) (
    input  logic  clk,
    input  logic  rst,
    input  pump_t st,
    output logic  locked
);
    localparam int RUN_W = $clog2(LOCK_RUN + 1);

    logic [WCNT_W-1:0] wcnt;
    logic [RUN_W-1:0]  run;
    logic [WCNT_W:0]   width;
    logic [RUN_W:0]    run_nxt;
    logic              good;

    assign width   = {1'b0, wcnt} + {{WCNT_W{1'b0}}, 1'b1};
    assign good    = width <= (WCNT_W + 1)'(WIDTH_LIM);
    assign run_nxt = {1'b0, run} + {{RUN_W{1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt   <= '0;
            run    <= '0;
            locked <= 1'b0;
        end else if (is_closing(st)) begin
            wcnt <= '0;
            if (good) begin
                if (run_nxt <= (RUN_W + 1)'(LOCK_RUN)) run <= run_nxt[RUN_W-1:0];
                locked <= run_nxt >= (RUN_W + 1)'(LOCK_RUN);
            end else begin
                run    <= '0;
                locked <= 1'b0;
            end
        end else if (is_active(st)) begin
            if (wcnt != {WCNT_W{1'b1}}) wcnt <= wcnt + 1'b1;
        end
    end
endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det
    import pfd_pkg::*;
#(
    parameter int LOCK_RUN  = DEF_LOCK_RUN,
    parameter int WIDTH_LIM = DEF_WIDTH_LIM,
    parameter int WCNT_W    = DEF_WCNT_W
) (
    input  logic clk,
    input  logic rst,
    input  logic fp_div_i,
    input  logic fc_div_i,
    output logic up_n_o,
    output logic dn_n_o,
    output logic lock_raw_o,
    output logic locked_o
);
    logic [1:0] lvl;
    logic [1:0] rise;
    pump_t      st;

    assign lvl[CH_VCO] = fp_div_i;
    assign lvl[CH_REF] = fc_div_i;

    pfd_edge #(.N(2)) u_edge (
        .clk  (clk),
        .lvl  (lvl),
        .rise (rise)
    );

    pfd_core u_core (
        .clk      (clk),
        .rst      (rst),
        .rise_ref (rise[CH_REF]),
        .rise_vco (rise[CH_VCO]),
        .st       (st)
    );

    pfd_lockq #(
        .LOCK_RUN  (LOCK_RUN),
        .WIDTH_LIM (WIDTH_LIM),
        .WCNT_W    (WCNT_W)
    ) u_lockq (
        .clk    (clk),
        .rst    (rst),
        .st     (st),
        .locked (locked_o)
    );

    assign up_n_o     = ~st.up;
    assign dn_n_o     = ~st.dn;
    assign lock_raw_o = ~(up_n_o & dn_n_o);
endmodule

// File: rtl/pfd_lock_det_chk.sv
module pfd_lock_det_chk (
    input logic clk,
    input logic rst,
    input logic fp_div_i,
    input logic fc_div_i,
    input logic up_n_o,
    input logic dn_n_o,
    input logic lock_raw_o,
    input logic locked_o
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (up_n_o && dn_n_o && !locked_o));

    // R4
    one_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        (!up_n_o && !dn_n_o) |=> (up_n_o && dn_n_o));

    // R2
    up_from_ref_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(up_n_o) |-> $past(fc_div_i));

    // R3
    dn_from_vco_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dn_n_o) |-> $past(fp_div_i));

    // R7
    lock_on_close_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> $past(!up_n_o && !dn_n_o));

    // R8
    unlock_on_close_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(locked_o) |-> $past(!up_n_o && !dn_n_o));

    // R6
    raw_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (up_n_o && dn_n_o) |-> !lock_raw_o);
endmodule

bind pfd_lock_det pfd_lock_det_chk u_chk (.*);

// File: tb/pfd_lock_det_bench.sv
module pfd_lock_det_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int width;
        int dir;      // 0 = down led, 1 = up led, 2 = coincident
        bit lock;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fp  = 1'b0;
    logic fc  = 1'b0;
    logic up_n, dn_n, lock_raw, locked;

    int n_chk  = 0;
    int n_fail = 0;
    int run_model = 0;
    bit done = 1'b0;
    bit mon_en = 1'b0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pfd_lock_det u_pfd_lock_det (
        .clk        (clk),
        .rst        (rst),
        .fp_div_i   (fp),
        .fc_div_i   (fc),
        .up_n_o     (up_n),
        .dn_n_o     (dn_n),
        .lock_raw_o (lock_raw),
        .locked_o   (locked)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver: one comparison, second edge d samples after the first
    task automatic cmp(input bit ref_first, input int d);
        exp_t e;
        e.width = d + 1;
        e.dir   = (d == 0) ? 2 : (ref_first ? 1 : 0);
        if (e.width <= 2) run_model = (run_model < 16) ? run_model + 1 : 16;
        else              run_model = 0;
        e.lock = (run_model >= 16);
        q.push_back(e);
        @(negedge clk);
        if (d == 0) begin
            fc = 1'b1; fp = 1'b1;
        end else begin
            if (ref_first) fc = 1'b1; else fp = 1'b1;
            repeat (d) @(negedge clk);
            fc = 1'b1; fp = 1'b1;
        end
        repeat (2) @(negedge clk);
        fc = 1'b0; fp = 1'b0;
        @(negedge clk);
        // R9: falling inputs open no pulse
        chk("R9 up_n after fall", up_n, 1);
        chk("R9 dn_n after fall", dn_n, 1);
        repeat (2) @(negedge clk);
    endtask

    // Monitor / scoreboard
    int  m_width = 0;
    int  m_dir   = 0;
    bit  m_open  = 1'b0;
    bit  m_close = 1'b0;
    always @(negedge clk) begin
        if (mon_en) begin
            chk("R6 lock_raw", lock_raw, (!up_n || !dn_n) ? 1 : 0);
            if (m_close) begin
                exp_t e;
                chk("R4 both high after overlap", {31'd0, up_n && dn_n}, 1);
                if (q.size() == 0) begin
                    chk("R2 unexpected comparison", 1, 0);
                end else begin
                    e = q.pop_front();
                    chk(e.dir == 1 ? "R2 width" : (e.dir == 0 ? "R3 width" : "R5 width"),
                        m_width, e.width);
                    chk("R2/R3 lead direction", m_dir, e.dir);
                    chk(e.width > 2 ? "R8 locked" : "R7 locked", {31'd0, locked}, {31'd0, e.lock});
                end
                m_close = 1'b0;
                m_open  = 1'b0;
                m_width = 0;
            end else if (!up_n || !dn_n) begin
                if (!m_open) begin
                    m_open = 1'b1;
                    m_dir  = (!up_n && !dn_n) ? 2 : (!up_n ? 1 : 0);
                end
                m_width++;
                if (!up_n && !dn_n) m_close = 1'b1;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        fc = 1'b1; // level during reset must not leave a pulse behind
        @(negedge clk);
        chk("R1 up_n in reset", up_n, 1);
        chk("R1 dn_n in reset", dn_n, 1);
        chk("R1 locked in reset", locked, 0);
        fc = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk("R1 up_n after reset", up_n, 1);
        chk("R1 dn_n after reset", dn_n, 1);
        chk("R1 lock_raw after reset", lock_raw, 0);
        chk("R1 locked after reset", locked, 0);
        mon_en = 1'b1;

        // R2/R3 shapes with long offsets
        cmp(1'b1, 3);
        cmp(1'b0, 4);
        cmp(1'b0, 0);          // R5
        // R7: build a run of tight comparisons up to the threshold
        for (int i = 0; i < 16; i++) cmp(i[0], (i % 3 == 1) ? 1 : 0);
        // R8: one length-3 comparison breaks lock
        cmp(1'b1, 2);
        for (int i = 0; i < 15; i++) cmp(~i[0], 1);
        cmp(1'b0, 0);          // 16th: lock again
        cmp(1'b0, 3);          // R8 again
        repeat (4) @(negedge clk);
        chk("R7 scoreboard drained", q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule